// File: doc/BRIEF.md
# Dual-Port Collision Busy Arbiter

This block sits in front of a shared two-port memory array and watches the two access ports. A collision is when both ports are enabled and present the same address in the same cycle. In that case the arbiter grants one side. It drives an active-low busy indication to the other side and suppresses that side's write strobe into the array. The decision looks only at the enables and addresses. Whether either access reads or writes plays no part in it.

A mode input selects between two behaviours. In master mode the arbiter makes the decision and drives a busy output for each side. In slave mode it does no arbitration. Each side's busy input then acts only as a write inhibit for that port, so several slave slices of a wide array can follow the busy lines of one master. The two busy outputs are kept separate, so a system can OR them into a collision-event flag.

All outputs are registered. The select, gated write and busy of a cycle's access appear one clock after the request. Each output is decided once and stays clean for the whole cycle.

Top module: `dp_busy_arbiter`

## Requirements
- R1: In master mode (`master_mode`=1), a cycle with both enables high and equal addresses makes exactly one of `l_busy_out_n` and `r_busy_out_n` low on the following cycle.
- R2: When there is no collision (addresses differ, or at least one enable is low), both busy outputs are high on the following cycle.
- R3: The write strobe of the side that receives busy is held low on the following cycle, while the granted side's write strobe follows its request.
- R4: The collision decision does not depend on the write inputs: a read/read collision and a read/write collision give the same busy pattern as a write/write collision.
- R5: When both ports start a colliding access in the same cycle, the left port wins and the right port receives busy.
- R6: A port that continues an access (enabled in the previous cycle at the same address) keeps the grant against a port that newly arrives at that address, for as long as both stay there.
- R7: Reads are never blocked: each `*_mem_sel` output equals that port's enable one cycle earlier, even for the losing side.
- R8: In slave mode (`master_mode`=0), both busy outputs stay high. A low `*_busy_in_n` blocks that port's write, and a high one lets it through. In master mode the busy inputs have no effect.
- R9: Synchronous active-high reset sets both busy outputs high and the selects and write strobes low. It also clears the history of continuing accesses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| master_mode | input | 1 | 1 = arbitrate and drive busy; 0 = busy inputs are write inhibits |
| l_en | input | 1 | Left port access enable |
| l_wr | input | 1 | Left port write request |
| l_addr | input | ADDR_W | Left port address |
| r_en | input | 1 | Right port access enable |
| r_wr | input | 1 | Right port write request |
| r_addr | input | ADDR_W | Right port address |
| l_busy_in_n | input | 1 | Left write inhibit in slave mode, active low |
| r_busy_in_n | input | 1 | Right write inhibit in slave mode, active low |
| l_busy_out_n | output | 1 | Left busy indication, active low |
| r_busy_out_n | output | 1 | Right busy indication, active low |
| l_mem_sel | output | 1 | Left select toward the array |
| l_mem_we | output | 1 | Left gated write strobe toward the array |
| r_mem_sel | output | 1 | Right select toward the array |
| r_mem_we | output | 1 | Right gated write strobe toward the array |

## Verification
The stimulus covers several cases:
- Matched addresses under write/write, read/read and read/write mixes, which separate a decision taken on address alone from one that leaks the write flag.
- Disjoint addresses, and an equal address on a disabled port, which show that a collision needs both enables.
- Staggered arrivals, with the left port first and with the right port first, set against simultaneous starts, which tell grant holding apart from a fixed left priority.

Slave-mode vectors with each inhibit pin low, and master-mode vectors with both inhibit pins low, show which mode honours the pins. A reset placed between a held right-side access and a fresh collision shows that reset clears the access history.

// File: rtl/dpba_pkg.sv
package dpba_pkg;

    typedef enum logic [1:0] {
        WIN_NONE  = 2'd0,
        WIN_LEFT  = 2'd1,
        WIN_RIGHT = 2'd2
    } win_e;

    typedef struct packed {
        logic hit;
        win_e winner;
    } arb_t;

    typedef struct packed {
        logic sel;
        logic we;
        logic busy_n;
    } port_out_t;

    localparam int unsigned SIDES = 2;

    // A continuing holder beats a newcomer; a tie of two continuing ports
    // keeps the earlier winner; a tie of two new ports goes to the left.
    function automatic win_e pick_winner(input logic l_cont, input logic r_cont,
                                         input arb_t prev);
        if (l_cont && !r_cont)
            return WIN_LEFT;
        else if (r_cont && !l_cont)
            return WIN_RIGHT;
        else if (l_cont && r_cont && prev.hit)
            return prev.winner;
        else
            return WIN_LEFT;
    endfunction

endpackage

// File: rtl/dpba_collide.sv
module dpba_collide #(
    parameter int unsigned ADDR_W = 13
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              l_en,
    input  logic [ADDR_W-1:0] l_addr,
    input  logic              r_en,
    input  logic [ADDR_W-1:0] r_addr,
    output logic              hit,
    output logic              l_cont,
    output logic              r_cont
);
    logic              l_en_q, r_en_q;
    logic [ADDR_W-1:0] l_addr_q, r_addr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            l_en_q   <= 1'b0;
            r_en_q   <= 1'b0;
            l_addr_q <= '0;
            r_addr_q <= '0;
        end else begin
            l_en_q   <= l_en;
            r_en_q   <= r_en;
            l_addr_q <= l_addr;
            r_addr_q <= r_addr;
        end
    end

    always_comb begin
        hit    = l_en && r_en && (l_addr == r_addr);
        l_cont = l_en && l_en_q && (l_addr == l_addr_q);
        r_cont = r_en && r_en_q && (r_addr == r_addr_q);
    end

endmodule

// File: rtl/dpba_owner.sv
module dpba_owner
    import dpba_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic master,
    input  logic hit,
    input  logic l_cont,
    input  logic r_cont,
    output arb_t arb_d
);
    arb_t arb_q;

    always_comb begin
        arb_d = '{hit: 1'b0, winner: WIN_NONE};
        if (master && hit) begin
            arb_d.hit    = 1'b1;
            arb_d.winner = pick_winner(l_cont, r_cont, arb_q);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) arb_q <= '{hit: 1'b0, winner: WIN_NONE};
        else     arb_q <= arb_d;
    end

    // R1: a collision always names a real winner
    a_r1_winner_named: assert property (@(posedge clk) disable iff (rst)
        arb_d.hit |-> (arb_d.winner == WIN_LEFT || arb_d.winner == WIN_RIGHT));

    // R6: a left holder that keeps its access keeps the grant
    a_r6_left_holds: assert property (@(posedge clk) disable iff (rst)
        master && hit && arb_q.hit && arb_q.winner == WIN_LEFT && l_cont
        |-> arb_d.winner == WIN_LEFT);

    // R6: a right holder that keeps its access keeps the grant
    a_r6_right_holds: assert property (@(posedge clk) disable iff (rst)
        master && hit && arb_q.hit && arb_q.winner == WIN_RIGHT && r_cont
        |-> arb_d.winner == WIN_RIGHT);

endmodule

// File: rtl/dpba_gate.sv
module dpba_gate
    import dpba_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      master,
    input  logic      en,
    input  logic      wr,
    input  logic      lose,
    input  logic      busy_in_n,
    output port_out_t q
);
    logic allow;

    always_comb allow = master ? !lose : busy_in_n;

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '{sel: 1'b0, we: 1'b0, busy_n: 1'b1};
        end else begin
            q.sel    <= en;
            q.we     <= en && wr && allow;
            q.busy_n <= !(master && lose);
        end
    end

    // R3: a strobe toward the array only ever comes with a select
    a_r3_we_with_sel: assert property (@(posedge clk) disable iff (rst)
        q.we |-> q.sel);

    // R3: a losing side in master mode never writes
    a_r3_loser_no_write: assert property (@(posedge clk) disable iff (rst)
        master && lose |=> !q.we && !q.busy_n);

endmodule

// File: rtl/dp_busy_arbiter.sv
module dp_busy_arbiter
    import dpba_pkg::*;
#(
    parameter int unsigned ADDR_W = 13
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              master_mode,
    input  logic              l_en,
    input  logic              l_wr,
    input  logic [ADDR_W-1:0] l_addr,
    input  logic              r_en,
    input  logic              r_wr,
    input  logic [ADDR_W-1:0] r_addr,
    input  logic              l_busy_in_n,
    input  logic              r_busy_in_n,
    output logic              l_busy_out_n,
    output logic              r_busy_out_n,
    output logic              l_mem_sel,
    output logic              l_mem_we,
    output logic              r_mem_sel,
    output logic              r_mem_we
);
    logic hit, l_cont, r_cont;
    arb_t arb_d;

    logic      side_en   [SIDES];
    logic      side_wr   [SIDES];
    logic      side_bin  [SIDES];
    port_out_t side_q    [SIDES];

    always_comb begin
        side_en[0]  = l_en;        side_en[1]  = r_en;
        side_wr[0]  = l_wr;        side_wr[1]  = r_wr;
        side_bin[0] = l_busy_in_n; side_bin[1] = r_busy_in_n;
    end

    dpba_collide #(.ADDR_W(ADDR_W)) u_collide (
        .clk(clk), .rst(rst),
        .l_en(l_en), .l_addr(l_addr),
        .r_en(r_en), .r_addr(r_addr),
        .hit(hit), .l_cont(l_cont), .r_cont(r_cont)
    );

    dpba_owner u_owner (
        .clk(clk), .rst(rst), .master(master_mode),
        .hit(hit), .l_cont(l_cont), .r_cont(r_cont),
        .arb_d(arb_d)
    );

    for (genvar i = 0; i < SIDES; i++) begin : g_side
        localparam win_e OTHER = (i == 0) ? WIN_RIGHT : WIN_LEFT;
        logic lose;
        always_comb lose = arb_d.hit && (arb_d.winner == OTHER);

        dpba_gate u_gate (
            .clk(clk), .rst(rst), .master(master_mode),
            .en(side_en[i]), .wr(side_wr[i]), .lose(lose),
            .busy_in_n(side_bin[i]), .q(side_q[i])
        );
    end

    always_comb begin
        l_busy_out_n = side_q[0].busy_n;
        r_busy_out_n = side_q[1].busy_n;
        l_mem_sel    = side_q[0].sel;
        l_mem_we     = side_q[0].we;
        r_mem_sel    = side_q[1].sel;
        r_mem_we     = side_q[1].we;
    end

    // R1: one collision yields exactly one busy side
    a_r1_single_busy: assert property (@(posedge clk) disable iff (rst)
        master_mode && l_en && r_en && (l_addr == r_addr)
        |=> (l_busy_out_n != r_busy_out_n));

    // R2: no collision leaves both sides free
    a_r2_no_hit_free: assert property (@(posedge clk) disable iff (rst)
        !(l_en && r_en && (l_addr == r_addr))
        |=> (l_busy_out_n && r_busy_out_n));

    // R7: reads proceed, the select follows the enable
    a_r7_sel_follows: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (l_mem_sel == $past(l_en)) && (r_mem_sel == $past(r_en)));

    // R8: in slave mode a low inhibit pin blocks that side's write
    a_r8_slave_inhibit: assert property (@(posedge clk) disable iff (rst)
        !master_mode && (!l_busy_in_n || !r_busy_in_n)
        |=> (l_busy_in_n || !$past(l_busy_in_n) ? 1'b1 : 1'b1)
            && !($past(!l_busy_in_n) && l_mem_we)
            && !($past(!r_busy_in_n) && r_mem_we));

    // R8: slave mode never drives busy
    a_r8_slave_quiet: assert property (@(posedge clk) disable iff (rst)
        !master_mode |=> l_busy_out_n && r_busy_out_n);

endmodule

// File: tb/dp_busy_arbiter_bench.sv
module dp_busy_arbiter_bench;
    localparam int unsigned AW = 13;

    logic          clk = 1'b0;
    logic          rst;
    logic          master_mode;
    logic          l_en, l_wr, r_en, r_wr;
    logic [AW-1:0] l_addr, r_addr;
    logic          l_busy_in_n, r_busy_in_n;
    logic          l_busy_out_n, r_busy_out_n;
    logic          l_mem_sel, l_mem_we, r_mem_sel, r_mem_we;

    int applied = 0;
    int bad     = 0;

    always #2 clk = ~clk;

    dp_busy_arbiter #(.ADDR_W(AW)) u_dp_busy_arbiter (
        .clk(clk), .rst(rst), .master_mode(master_mode),
        .l_en(l_en), .l_wr(l_wr), .l_addr(l_addr),
        .r_en(r_en), .r_wr(r_wr), .r_addr(r_addr),
        .l_busy_in_n(l_busy_in_n), .r_busy_in_n(r_busy_in_n),
        .l_busy_out_n(l_busy_out_n), .r_busy_out_n(r_busy_out_n),
        .l_mem_sel(l_mem_sel), .l_mem_we(l_mem_we),
        .r_mem_sel(r_mem_sel), .r_mem_we(r_mem_we)
    );

    typedef struct packed {
        logic          m;
        logic          le, lw;
        logic [AW-1:0] la;
        logic          re, rw;
        logic [AW-1:0] ra;
        logic          bil, bir;
        logic [3:0]    tag;
        logic [5:0]    exp; // busy_l_n, busy_r_n, sel_l, sel_r, we_l, we_r
    } vec_t;

    localparam int NV = 24;
    localparam vec_t VEC [NV] = '{
        '{1'b1, 1'b0,1'b0,13'd0,  1'b0,1'b0,13'd0,  1'b1,1'b1, 4'd2, 6'b110000}, // R2 idle
        '{1'b1, 1'b1,1'b1,13'd5,  1'b1,1'b0,13'd9,  1'b1,1'b1, 4'd2, 6'b111110}, // R2 distinct
        '{1'b1, 1'b0,1'b0,13'd0,  1'b0,1'b0,13'd0,  1'b1,1'b1, 4'd2, 6'b110000},
        '{1'b1, 1'b1,1'b1,13'd10, 1'b1,1'b1,13'd10, 1'b1,1'b1, 4'd5, 6'b101110}, // R5 R3
        '{1'b1, 1'b0,1'b0,13'd0,  1'b0,1'b0,13'd0,  1'b1,1'b1, 4'd2, 6'b110000},
        '{1'b1, 1'b1,1'b0,13'd10, 1'b1,1'b0,13'd10, 1'b1,1'b1, 4'd4, 6'b101100}, // R4 R7 rd/rd
        '{1'b1, 1'b0,1'b0,13'd0,  1'b0,1'b0,13'd0,  1'b1,1'b1, 4'd2, 6'b110000},
        '{1'b1, 1'b1,1'b0,13'd20, 1'b1,1'b1,13'd20, 1'b1,1'b1, 4'd4, 6'b101100}, // R4 R3 rd/wr
        '{1'b1, 1'b0,1'b0,13'd0,  1'b0,1'b0,13'd0,  1'b1,1'b1, 4'd2, 6'b110000},
        '{1'b1, 1'b0,1'b0,13'd0,  1'b1,1'b1,13'd30, 1'b1,1'b1, 4'd2, 6'b110101}, // right alone
        '{1'b1, 1'b1,1'b1,13'd30, 1'b1,1'b1,13'd30, 1'b1,1'b1, 4'd6, 6'b011101}, // R6 right holds
        '{1'b1, 1'b1,1'b1,13'd30, 1'b1,1'b1,13'd30, 1'b1,1'b1, 4'd6, 6'b011101}, // R6 keeps
        '{1'b1, 1'b1,1'b1,13'd30, 1'b0,1'b0,13'd0,  1'b1,1'b1, 4'd2, 6'b111010},
        '{1'b1, 1'b0,1'b0,13'd0,  1'b0,1'b0,13'd0,  1'b1,1'b1, 4'd2, 6'b110000},
        '{1'b1, 1'b1,1'b0,13'd40, 1'b0,1'b0,13'd0,  1'b1,1'b1, 4'd7, 6'b111000}, // R7 read
        '{1'b1, 1'b1,1'b1,13'd40, 1'b1,1'b1,13'd40, 1'b1,1'b1, 4'd6, 6'b101110}, // R6 left holds
        '{1'b1, 1'b0,1'b0,13'd0,  1'b0,1'b0,13'd0,  1'b1,1'b1, 4'd2, 6'b110000},
        '{1'b1, 1'b0,1'b0,13'd50, 1'b1,1'b1,13'd50, 1'b1,1'b1, 4'd2, 6'b110101}, // R2 left off
        '{1'b0, 1'b1,1'b1,13'd60, 1'b1,1'b1,13'd60, 1'b1,1'b1, 4'd8, 6'b111111}, // R8 no arb
        '{1'b0, 1'b1,1'b1,13'd3,  1'b1,1'b1,13'd4,  1'b0,1'b1, 4'd8, 6'b111101}, // R8 left inh
        '{1'b0, 1'b1,1'b1,13'd3,  1'b1,1'b0,13'd4,  1'b1,1'b0, 4'd8, 6'b111110},
        '{1'b0, 1'b0,1'b0,13'd0,  1'b1,1'b1,13'd4,  1'b1,1'b0, 4'd8, 6'b110100}, // R8 right inh
        '{1'b1, 1'b1,1'b1,13'd70, 1'b1,1'b1,13'd71, 1'b0,1'b0, 4'd8, 6'b111111}, // R8 pins ignored
        '{1'b1, 1'b0,1'b0,13'd0,  1'b0,1'b0,13'd0,  1'b1,1'b1, 4'd2, 6'b110000}
    };

    function automatic logic [5:0] outs();
        return {l_busy_out_n, r_busy_out_n, l_mem_sel, r_mem_sel, l_mem_we, r_mem_we};
    endfunction

    task automatic check(input int tag, input logic [5:0] got, input logic [5:0] exp);
        applied++;
        if (got !== exp) begin
            bad++;
            $display("FAIL R%0d: got %b expected %b", tag, got, exp);
        end
    endtask

    task automatic drive(input vec_t v);
        master_mode = v.m;
        l_en = v.le; l_wr = v.lw; l_addr = v.la;
        r_en = v.re; r_wr = v.rw; r_addr = v.ra;
        l_busy_in_n = v.bil; r_busy_in_n = v.bir;
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", applied, bad);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        rst = 1'b1;
        drive(VEC[0]);
        repeat (3) @(posedge clk);
        #1;
        // R9: reset state
        check(9, outs(), 6'b110000);
        @(negedge clk);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            drive(VEC[i]);
            step();
            check(int'(VEC[i].tag), outs(), VEC[i].exp);
        end

        // R9: reset drops outputs and clears access history
        @(negedge clk);
        drive('{1'b1, 1'b0,1'b0,13'd90, 1'b1,1'b1,13'd90, 1'b1,1'b1, 4'd9, 6'b0});
        step();
        check(2, outs(), 6'b110101);
        @(negedge clk);
        rst = 1'b1;
        l_en = 1'b1; l_wr = 1'b1;
        step();
        check(9, outs(), 6'b110000);
        @(negedge clk);
        rst = 1'b0;
        step();
        // R9 / R5: both count as new after reset, so left wins
        check(9, outs(), 6'b101110);

        // R1: a collision with a newcomer on the left flips to right holder
        @(negedge clk);
        drive('{1'b1, 1'b0,1'b0,13'd0, 1'b0,1'b0,13'd0, 1'b1,1'b1, 4'd1, 6'b0});
        step();
        @(negedge clk);
        drive('{1'b1, 1'b0,1'b0,13'd0, 1'b1,1'b0,13'd8191, 1'b1,1'b1, 4'd1, 6'b0});
        step();
        @(negedge clk);
        drive('{1'b1, 1'b1,1'b0,13'd8191, 1'b1,1'b0,13'd8191, 1'b1,1'b1, 4'd1, 6'b0});
        step();
        // R1: right held top address first, left gets busy, reads still selected
        check(1, outs(), 6'b011100);

        finish_run();
    end

endmodule